// File: doc/BRIEF.md
# Serial EEPROM Memory Engine

This block is the memory-side core of a byte-addressed serial EEPROM. A bus front end, which handles the two-wire line level and bit timing, hands it start and stop indications, received bytes and the master's acknowledge after each byte read. The engine decodes the transaction, holds the word-address counter and owns a small register array. It supplies the acknowledge for each accepted byte and the next byte to shift out. While the self-timed write cycle runs, it reports busy.

The first byte after a start is the header, and its bit 0 selects read (1) or write (0). In a write, the next byte loads the word address. Each byte after that goes into a page staging buffer at the current page offset, and only the offset bits advance. At the stop, all staged bytes are written into the array in one cycle and a busy window of a parameter-set length begins. Reads return the byte at the counter and advance it across the whole array. When the array is wider than 256 bytes, header bits [ADDR_W-8:1] supply the word-address bits above bit 7 for writes.

Top module: `ser_mem_engine`

## Requirements
- R1: After reset `o_busy` and `o_ack` are 0, the address counter is 0 and every array byte reads 8'hFF.
- R2: A byte accepted while a transaction is open raises `o_ack` for one cycle, in the cycle after the byte. A byte that arrives with no start since the last stop gets no acknowledge.
- R3: In a write transaction the second byte is the word address. Each later byte is stored at that address, with the address advancing after each byte. The array changes only at the closing stop.
- R4: During a write only the low PAGE_W address bits (3 for ADDR_W ≤ 8, 4 otherwise) advance. A byte past the page end lands at the start of the same page, and the later byte wins.
- R5: A partial page write changes only the bytes received. The other bytes of the page keep their values.
- R6: A stop that commits data holds `o_busy` high for exactly WR_CYC cycles, starting in the cycle after the stop. While busy, starts, bytes and master acknowledges are ignored and no acknowledge is given.
- R7: Between transactions the counter holds the last accessed address plus one. A read header returns the byte at the counter on `o_rd_data` in the cycle after the header.
- R8: A write transaction that carries only a word address, followed by a repeated start and a read header, returns the byte at that word address.
- R9: In a read, each master acknowledge of 1 presents the next byte in the following cycle, wrapping from the last array byte to byte 0. A master acknowledge of 0 ends the read.
- R10: With `i_wp` high at the stop, a write is still acknowledged byte by byte, but the array is not changed and `o_busy` stays low.
- R11: A stop after only the word address, a stop during a read, and a repeated start after data bytes all leave the array unchanged and start no busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_start | input | 1 | Start or repeated start seen on the bus (one-cycle pulse) |
| i_stop | input | 1 | Stop seen on the bus (one-cycle pulse) |
| i_byte_vld | input | 1 | A byte from the master is complete |
| i_byte | input | 8 | Byte received from the master |
| i_mack_vld | input | 1 | Master acknowledge slot after a read byte is complete |
| i_mack | input | 1 | 1 = master acknowledged (continue), 0 = no acknowledge |
| i_wp | input | 1 | Write protect; high blocks array updates |
| o_ack | output | 1 | Acknowledge for the previously accepted byte |
| o_rd_data | output | 8 | Byte to send during a read |
| o_busy | output | 1 | Self-timed write cycle in progress |

## Verification
The end of the busy window and a new start can meet in one cycle. A start sampled in the final busy cycle must be dropped, and a start one cycle later must be served. The bench counts the busy cycles after a commit. It issues a start and a header on exactly the last busy cycle and expects no acknowledge. It then opens a fresh read and expects the counter value left by the write. Random page writes of 0 to 20 bytes, some protected, are checked against a bench array model through sequential reads.

// File: rtl/sme_pkg.sv
package sme_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_WADR,
      ST_WDAT,
      ST_RD
   } sme_state_e;

   // Page offset width: 8-byte pages up to 256 bytes, 16-byte pages above
   function automatic int sme_page_w(input int aw);
      return (aw <= 8) ? 3 : 4;
   endfunction

endpackage

// File: rtl/sme_page_buf.sv
module sme_page_buf #(
   parameter int PAGE_W = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      i_clr,
   input  logic                      i_we,
   input  logic [PAGE_W-1:0]         i_ofs,
   input  logic [7:0]                i_dat,
   output logic [(8<<PAGE_W)-1:0]    o_dat,
   output logic [(1<<PAGE_W)-1:0]    o_mask
);
   localparam int PAGE = 1 << PAGE_W;

   generate
      for (genvar g = 0; g < PAGE; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               o_dat[g*8 +: 8] <= 8'h00;
               o_mask[g]       <= 1'b0;
            end else if (i_clr) begin
               o_mask[g]       <= 1'b0;
            end else if (i_we && (i_ofs == PAGE_W'(g))) begin
               o_dat[g*8 +: 8] <= i_dat;
               o_mask[g]       <= 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sme_array.sv
module sme_array #(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      i_commit,
   input  logic [ADDR_W-PAGE_W-1:0]  i_page,
   input  logic [(8<<PAGE_W)-1:0]    i_dat,
   input  logic [(1<<PAGE_W)-1:0]    i_mask,
   input  logic [ADDR_W-1:0]         i_raddr,
   output logic [7:0]                o_rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (PAGE_W >= ADDR_W) begin : g_bad_geom
         $error("sme_array: page offset must be narrower than the address");
      end
   endgenerate

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem[k] <= 8'hFF;
      end else if (i_commit) begin
         for (int k = 0; k < DEPTH; k++) begin
            if ((k[ADDR_W-1:PAGE_W] == i_page) && i_mask[k[PAGE_W-1:0]])
               mem[k] <= i_dat[k[PAGE_W-1:0]*8 +: 8];
         end
      end
   end

   assign o_rdata = mem[i_raddr];

endmodule

// File: rtl/sme_busy_timer.sv
module sme_busy_timer #(
   parameter int CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic i_fire,
   output logic o_busy
);
   localparam int CW = $clog2(CYC + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (i_fire)         cnt <= CW'(CYC);
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign o_busy = (cnt != '0);

endmodule

// File: rtl/ser_mem_engine.sv
module ser_mem_engine #(
   parameter int ADDR_W = 8,
   parameter int WR_CYC = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        i_start,
   input  logic        i_stop,
   input  logic        i_byte_vld,
   input  logic [7:0]  i_byte,
   input  logic        i_mack_vld,
   input  logic        i_mack,
   input  logic        i_wp,
   output logic        o_ack,
   output logic [7:0]  o_rd_data,
   output logic        o_busy
);
   import sme_pkg::*;

   localparam int PAGE_W = sme_page_w(ADDR_W);
   localparam int PAGE   = 1 << PAGE_W;
   localparam int PG_W   = ADDR_W - PAGE_W;
   localparam int HI_W   = (ADDR_W > 8) ? ADDR_W - 8 : 0;

   generate
      if (ADDR_W < 7 || ADDR_W > 11) begin : g_bad_aw
         $error("ser_mem_engine: ADDR_W must lie in 7..11");
      end
      if (WR_CYC < 1) begin : g_bad_cyc
         $error("ser_mem_engine: WR_CYC must be at least 1");
      end
   endgenerate

   sme_state_e           st;
   logic [ADDR_W-1:0]    ctr;
   logic [ADDR_W-1:0]    wa;
   logic                 pend;
   logic                 live;
   logic                 ev_byte;
   logic                 hdr_take;
   logic                 commit;
   logic                 buf_we;
   logic                 buf_clr;
   logic [7:0]           arr_rd;
   logic [PAGE*8-1:0]    buf_dat;
   logic [PAGE-1:0]      buf_mask;

   assign live     = !o_busy;
   assign ev_byte  = live && !i_start && !i_stop && i_byte_vld;
   assign hdr_take = ev_byte && (st == ST_HDR);
   assign buf_we   = ev_byte && (st == ST_WDAT);
   assign buf_clr  = live && (i_start || i_stop);
   assign commit   = live && !i_start && i_stop && (st == ST_WDAT) && pend && !i_wp;

   // Word-address composition: wide arrays take upper bits from the header
   generate
      if (HI_W > 0) begin : g_hi_addr
         logic [HI_W-1:0] hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        hi_q <= '0;
            else if (hdr_take) hi_q <= i_byte[HI_W:1];
         end
         assign wa = {hi_q, i_byte};
      end else begin : g_lo_addr
         assign wa = i_byte[ADDR_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ctr       <= '0;
         pend      <= 1'b0;
         o_ack     <= 1'b0;
         o_rd_data <= 8'h00;
      end else begin
         o_ack <= 1'b0;
         if (live) begin
            if (i_start) begin
               st   <= ST_HDR;
               pend <= 1'b0;
            end else if (i_stop) begin
               st   <= ST_IDLE;
               pend <= 1'b0;
            end else if (i_byte_vld) begin
               case (st)
                  ST_HDR: begin
                     o_ack <= 1'b1;
                     if (i_byte[0]) begin
                        st        <= ST_RD;
                        o_rd_data <= arr_rd;
                        ctr       <= ctr + 1'b1;
                     end else begin
                        st <= ST_WADR;
                     end
                  end
                  ST_WADR: begin
                     o_ack <= 1'b1;
                     ctr   <= wa;
                     st    <= ST_WDAT;
                  end
                  ST_WDAT: begin
                     o_ack <= 1'b1;
                     pend  <= 1'b1;
                     ctr   <= {ctr[ADDR_W-1:PAGE_W], ctr[PAGE_W-1:0] + 1'b1};
                  end
                  default: ;
               endcase
            end else if (i_mack_vld && (st == ST_RD)) begin
               if (i_mack) begin
                  o_rd_data <= arr_rd;
                  ctr       <= ctr + 1'b1;
               end else begin
                  st <= ST_IDLE;
               end
            end
         end
      end
   end

   sme_page_buf #(.PAGE_W(PAGE_W)) u_pbuf (
      .clk    (clk),
      .rst_n  (rst_n),
      .i_clr  (buf_clr),
      .i_we   (buf_we),
      .i_ofs  (ctr[PAGE_W-1:0]),
      .i_dat  (i_byte),
      .o_dat  (buf_dat),
      .o_mask (buf_mask)
   );

   sme_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .i_commit (commit),
      .i_page   (ctr[ADDR_W-1:PAGE_W]),
      .i_dat    (buf_dat),
      .i_mask   (buf_mask),
      .i_raddr  (ctr),
      .o_rdata  (arr_rd)
   );

   sme_busy_timer #(.CYC(WR_CYC)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .i_fire (commit),
      .o_busy (o_busy)
   );

   logic unused_pg;
   assign unused_pg = ^PG_W;

endmodule

// File: rtl/sme_checker.sv
module sme_checker #(
   parameter int WR_CYC = 64
) (
   input logic clk,
   input logic rst_n,
   input logic i_stop,
   input logic i_byte_vld,
   input logic i_wp,
   input logic o_ack,
   input logic o_busy
);
   int unsigned run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run <= 0;
      else if (o_busy) run <= run + 1;
      else             run <= 0;
   end

   // R6: busy window length
   p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(o_busy) |-> (run == WR_CYC));

   // R6: nothing acknowledged while busy
   p_no_ack_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      o_busy |=> !o_ack);

   // R3: busy only begins right after a stop
   p_busy_after_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(o_busy) |-> $past(i_stop));

   // R10: a protected stop never starts a write cycle
   p_wp_no_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(o_busy) |-> !$past(i_wp));

   // R2: an acknowledge always answers a received byte
   p_ack_has_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      o_ack |-> $past(i_byte_vld));

endmodule

bind ser_mem_engine sme_checker #(.WR_CYC(WR_CYC)) u_sme_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .i_stop     (i_stop),
   .i_byte_vld (i_byte_vld),
   .i_wp       (i_wp),
   .o_ack      (o_ack),
   .o_busy     (o_busy)
);

// File: tb/ser_mem_engine_bench.sv
module ser_mem_engine_bench;
   localparam int DEPTH = 256;
   localparam int PG    = 8;
   localparam int WRC   = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       i_start = 1'b0, i_stop = 1'b0, i_byte_vld = 1'b0;
   logic [7:0] i_byte = 8'h00;
   logic       i_mack_vld = 1'b0, i_mack = 1'b0, i_wp = 1'b0;
   logic       o_ack, o_busy;
   logic [7:0] o_rd_data;

   always #4 clk = ~clk;

   ser_mem_engine u_ser_mem_engine (
      .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_stop(i_stop),
      .i_byte_vld(i_byte_vld), .i_byte(i_byte), .i_mack_vld(i_mack_vld),
      .i_mack(i_mack), .i_wp(i_wp), .o_ack(o_ack), .o_rd_data(o_rd_data),
      .o_busy(o_busy)
   );

   int checks = 0, errors = 0;
   bit [7:0] mdl [DEPTH];
   int m_ctr = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_start();
      i_start = 1'b1; @(negedge clk); i_start = 1'b0;
   endtask

   task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
      i_byte_vld = 1'b1; i_byte = b; @(negedge clk); i_byte_vld = 1'b0;
      chk(o_ack == exp_ack, req, "ack", o_ack, exp_ack);
   endtask

   task automatic mack(input bit a);
      i_mack_vld = 1'b1; i_mack = a; @(negedge clk); i_mack_vld = 1'b0;
   endtask

   task automatic stop_wait(input int exp_busy, input string req);
      int n = 0;
      i_stop = 1'b1; @(negedge clk); i_stop = 1'b0;
      while (o_busy && n < 1000) begin n++; @(negedge clk); end
      chk(n == exp_busy, req, "busy cycles", n, exp_busy);
   endtask

   function automatic int pg_addr(input int a, input int k);
      return (a & ~(PG-1)) | ((a + k) % PG);
   endfunction

   task automatic wr_txn(input int a, input int n, input bit wp, input string req);
      i_wp = wp;
      do_start();
      send(8'hA0, 1'b1, "R2");
      send(8'(a), 1'b1, req);
      for (int k = 0; k < n; k++) begin
         logic [7:0] d = 8'($urandom);
         send(d, 1'b1, req);
         if (!wp) mdl[pg_addr(a, k)] = d;
      end
      m_ctr = (n == 0) ? a : pg_addr(a, n);
      stop_wait((n > 0 && !wp) ? WRC : 0, wp ? "R10" : (n == 0 ? "R11" : "R6"));
      i_wp = 1'b0;
   endtask

   task automatic rd_txn(input int n, input string req);
      do_start();
      send(8'hA1, 1'b1, "R2");
      for (int k = 0; k < n; k++) begin
         chk(o_rd_data == mdl[m_ctr], req, "read data", o_rd_data, mdl[m_ctr]);
         m_ctr = (m_ctr + 1) % DEPTH;
         mack(k < n - 1);
      end
      stop_wait(0, "R11");
   endtask

   task automatic rnd_read(input int a, input int n, input string req);
      do_start();
      send(8'hA0, 1'b1, "R2");
      send(8'(a), 1'b1, "R8");
      m_ctr = a;
      rd_txn(n, req);
   endtask

   initial begin
      #(8 * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int k = 0; k < DEPTH; k++) mdl[k] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(o_busy == 1'b0, "R1", "busy", o_busy, 0);
      chk(o_ack == 1'b0, "R1", "ack", o_ack, 0);
      rd_txn(2, "R1");           // counter 0, erased contents

      // R2: byte with no open transaction is not acknowledged
      send(8'hA0, 1'b0, "R2");

      // R3/R8: single byte write then random read
      wr_txn(8'h10, 1, 1'b0, "R3");
      rnd_read(8'h10, 1, "R8");

      // R4: page wrap within page 0x18..0x1F
      wr_txn(8'h1E, 10, 1'b0, "R4");
      rnd_read(8'h18, 8, "R4");

      // R5: partial page
      wr_txn(8'h42, 3, 1'b0, "R5");
      rnd_read(8'h40, 8, "R5");

      // R7: current address after a write
      wr_txn(8'h63, 2, 1'b0, "R3");
      rd_txn(3, "R7");

      // R9: sequential read wraps at array end
      wr_txn(8'hFE, 2, 1'b0, "R3");
      rnd_read(8'hFE, 4, "R9");

      // R6: start on the final busy cycle is ignored, next one is served
      begin
         int n = 0;
         do_start();
         send(8'hA0, 1'b1, "R2");
         send(8'h80, 1'b1, "R3");
         send(8'h5A, 1'b1, "R3");
         mdl[8'h80] = 8'h5A; m_ctr = 8'h81;
         i_stop = 1'b1; @(negedge clk); i_stop = 1'b0;
         repeat (63) begin if (o_busy) n++; @(negedge clk); end
         chk(n == 63 && o_busy == 1'b1, "R6", "busy before last", n, 63);
         do_start();
         chk(o_busy == 1'b0, "R6", "busy after window", o_busy, 0);
         send(8'hA1, 1'b0, "R6");
         rd_txn(1, "R7");
      end

      // R10: protected write acknowledged but discarded
      wr_txn(8'h20, 4, 1'b1, "R10");
      rnd_read(8'h20, 4, "R10");

      // R11: address-only stop, repeated start after data
      wr_txn(8'h30, 0, 1'b0, "R11");
      do_start();
      send(8'hA0, 1'b1, "R2");
      send(8'h33, 1'b1, "R11");
      send(8'hC3, 1'b1, "R11");
      send(8'h3C, 1'b1, "R11");
      m_ctr = 8'h35;
      rd_txn(1, "R11");
      rnd_read(8'h33, 2, "R11");

      // Random page writes checked through sequential reads
      for (int it = 0; it < 24; it++) begin
         int a = $urandom % DEPTH;
         int n = $urandom % 21;
         bit wp = ($urandom % 5) == 0;
         wr_txn(a, n, wp, "R4");
         rnd_read(a & ~(PG-1), PG + 1, "R9");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule